// File: doc/BRIEF.md
# Digital Input Edge Recorder

This block takes one or more 24 V digital input bits that have already been thresholded and carried across the isolation barrier, and turns each into a record of accepted edges. Every input goes through a two-stage synchronizer. A programmable debounce window then turns a burst of chatter into at most one accepted change of the clean level. Each accepted edge is stamped with a free-running local timebase. The width of each accepted pulse is measured on its falling edge and compared with a programmable glitch limit.

Per channel, two saturating counters keep a running audit: one for genuine events and one for glitches. Every accepted edge is queued in an eight-entry FIFO together with its channel, polarity, timestamp, width and the front-end fault bits seen at the same instant. This lets an electrical fault be told apart from a debounce mistake when the records are read back. A sticky flag reports any edge that had to be dropped. A configuration flag reports a debounce window that would swallow pulses at the glitch limit.

Top module: `di_event_recorder`

## Requirements
- R1: Each input passes through two synchronizing flops. The clean level takes a new value only after the synchronized input has differed from it for cfg_win_i+1 consecutive cycles. A shorter burst leaves the level unchanged and records nothing.
- R2: Acceptance latency is fixed. When an input changes between two rising edges and then holds, `level_o` shows the new value after exactly cfg_win_i+3 rising edges.
- R3: The timebase is a TS_W-bit counter that starts at 0 after reset and advances every cycle. Each record carries its value in the cycle the edge was accepted. For a pulse held for L cycles, the fall record's timestamp minus the rise record's timestamp equals L.
- R4: A fall record carries the pulse width, equal to the timestamp difference of R3. A rise record carries width 0.
- R5: On a falling acceptance, a width below cfg_glitch_i increments the channel's glitch counter. A width at or above it increments the event counter. Rising acceptances change neither counter.
- R6: Both counters stop at all ones. A one on `cnt_clr_i` zeroes every counter of every channel, and this takes precedence over an increment in the same cycle.
- R7: Records leave the FIFO in acceptance order. The head is visible on `fifo_data_o` while `fifo_valid_o` is 1. The layout from MSB to LSB is {channel (CH_W bits), polarity (1 = rising), fault (3 bits), timestamp (TS_W), width (TS_W)}. A pop while empty has no effect.
- R8: The FIFO holds 8 records. A new record is dropped when the FIFO is full and no pop happens in that cycle. When several channels accept in the same cycle, only the lowest-numbered channel is stored. Any dropped record sets `ovf_o`, which stays set until `ovf_clr_i`.
- R9: The three front-end fault bits of each channel (bit 0 open, bit 1 short, bit 2 overvoltage) pass through the same synchronizer as the input. The values present at acceptance are stored in the record.
- R10: `cfg_bad_o` is 1 exactly when cfg_win_i is greater than or equal to cfg_glitch_i.
- R11: After reset the level, counters, FIFO valid and overflow flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din_i | input | NCH | Thresholded, isolated input bits |
| fault_i | input | NCH*3 | Front-end status per channel (open, short, overvoltage) |
| cfg_win_i | input | WIN_W | Debounce window in cycles |
| cfg_glitch_i | input | TS_W | Minimum width of a genuine event |
| cnt_clr_i | input | 1 | Write-one strobe that clears all counters |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| fifo_pop_i | input | 1 | Removes the head record |
| level_o | output | NCH | Debounced level per channel |
| fifo_valid_o | output | 1 | FIFO holds at least one record |
| fifo_data_o | output | CH_W+4+2*TS_W | Head record |
| ovf_o | output | 1 | Sticky dropped-record flag |
| evt_cnt_o | output | NCH*CNT_W | Event counters, channel 0 in the low bits |
| glt_cnt_o | output | NCH*CNT_W | Glitch counters, channel 0 in the low bits |
| cfg_bad_o | output | 1 | Debounce window not shorter than glitch limit |

## Verification
Some behaviour is checked every cycle by the assertions. The clean level may only move toward a value the synchronized input already showed. The counters hold at all ones and move only on a falling acceptance. The FIFO occupancy stays within its depth and does not grow when full. Any dropped record raises the sticky flag, and the flag only falls on its clear. Other behaviour needs the bench's directed scenarios: the exact acceptance latency, rejection of chatter shorter than the window, timestamp and width values, the classification boundary at the glitch limit, record order and layout, fault capture, and lowest-channel priority on colliding edges.

// File: rtl/di_evt_pkg.sv
// Package: shared constants and helpers for the digital input edge recorder.
// Assumes nothing beyond standard elaboration-time evaluation.
package di_evt_pkg;
    localparam int FLT_W = 3;

    // Bit positions inside a channel's fault field.
    typedef enum int {
        FLT_OPEN  = 0,
        FLT_SHORT = 1,
        FLT_OVERV = 2
    } flt_bit_e;

    // Width of a channel index; at least one bit.
    function automatic int chan_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/di_sync.sv
// Two-flop synchronizer for a vector of asynchronous bits.
// Assumes each bit is independent; no cross-bit coherence is implied.
module di_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Two register stages clear to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/di_chan.sv
// One input channel: debounce, edge acceptance, pulse width measurement,
// glitch/event classification and saturating audit counters.
// Assumes s_i is already synchronized and ts_i advances by one per cycle.
module di_chan #(
    parameter int TS_W  = 16,
    parameter int WIN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic [WIN_W-1:0] cfg_win_i,
    input  logic [TS_W-1:0]  cfg_glitch_i,
    input  logic             cnt_clr_i,
    output logic             lvl_o,
    output logic             acc_o,
    output logic             pol_o,
    output logic [TS_W-1:0]  width_o,
    output logic [CNT_W-1:0] evt_cnt_o,
    output logic [CNT_W-1:0] glt_cnt_o
);
    logic [WIN_W-1:0] run;
    logic [TS_W-1:0]  rise_ts;
    logic             fall_acc;
    logic             is_glt;

    // Acceptance happens in the cycle the run of differing samples reaches the window.
    always_comb begin
        acc_o    = (s_i != lvl_o) && (run == cfg_win_i);
        pol_o    = s_i;
        fall_acc = acc_o && !s_i;
        width_o  = fall_acc ? (ts_i - rise_ts) : '0;
        is_glt   = width_o < cfg_glitch_i;
    end

    // Debounce: count consecutive differing samples, adopt the new level on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
            run   <= '0;
        end else if (s_i == lvl_o) begin
            run <= '0;
        end else if (acc_o) begin
            lvl_o <= s_i;
            run   <= '0;
        end else begin
            run <= run + WIN_W'(1);
        end
    end

    // Remember the timestamp of the last accepted rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)              rise_ts <= '0;
        else if (acc_o && s_i)   rise_ts <= ts_i;
    end

    // Saturating event and glitch counters with a clear strobe that wins.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr_i) begin
            evt_cnt_o <= '0;
            glt_cnt_o <= '0;
        end else if (fall_acc) begin
            if (is_glt) begin
                if (glt_cnt_o != '1) glt_cnt_o <= glt_cnt_o + CNT_W'(1);
            end else begin
                if (evt_cnt_o != '1) evt_cnt_o <= evt_cnt_o + CNT_W'(1);
            end
        end
    end

    // R1: the level only moves to a value the synchronized input showed.
    a_r1_level_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_o) |-> ($past(s_i) == lvl_o));

    // R5: the event counter moves only on a non-glitch falling acceptance.
    a_r5_evt_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fall_acc && !is_glt) && !cnt_clr_i) |=> $stable(evt_cnt_o));

    // R5: the glitch counter moves only on a glitch falling acceptance.
    a_r5_glt_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fall_acc && is_glt) && !cnt_clr_i) |=> $stable(glt_cnt_o));

    // R6: a full event counter stays full unless cleared.
    a_r6_evt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_cnt_o == '1 && !cnt_clr_i) |=> (evt_cnt_o == '1));

    // R6: a full glitch counter stays full unless cleared.
    a_r6_glt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (glt_cnt_o == '1 && !cnt_clr_i) |=> (glt_cnt_o == '1));
endmodule

// File: rtl/di_fifo.sv
// Synchronous record FIFO with drop-on-full and a drop indication.
// Assumes DEPTH is a power of two; a push while full is accepted only with a pop.
module di_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         valid_o,
    output logic         drop_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, pop_ok, push_ok;

    // Effective push and pop decisions for this cycle.
    always_comb begin
        full    = (cnt == CW'(DEPTH));
        pop_ok  = pop_i && (cnt != '0);
        push_ok = push_i && (!full || pop_ok);
        drop_o  = push_i && !push_ok;
        valid_o = (cnt != '0);
        dout_o  = mem[rp];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din_i;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= wp + AW'(1);
            if (pop_ok)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // R8: occupancy never exceeds the depth.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R8: a full FIFO with no pop stays full and drops the push.
    a_r8_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop_i) |=> (cnt == CW'(DEPTH)));

    // R7: popping an empty FIFO with no push leaves it empty.
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && pop_i && !push_i) |=> (cnt == '0));
endmodule

// File: rtl/di_event_recorder.sv
// Top: synchronizes inputs and fault bits, runs one debounce channel per
// input, stamps accepted edges, queues records and keeps an overflow flag.
// Assumes WIN_W <= TS_W and that pulses stay shorter than 2**TS_W cycles.
module di_event_recorder
    import di_evt_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int TS_W       = 16,
    parameter int WIN_W      = 8,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int CH_W      = chan_bits(NCH),
    localparam int REC_W     = CH_W + 1 + FLT_W + 2 * TS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       din_i,
    input  logic [NCH*FLT_W-1:0] fault_i,
    input  logic [WIN_W-1:0]     cfg_win_i,
    input  logic [TS_W-1:0]      cfg_glitch_i,
    input  logic                 cnt_clr_i,
    input  logic                 ovf_clr_i,
    input  logic                 fifo_pop_i,
    output logic [NCH-1:0]       level_o,
    output logic                 fifo_valid_o,
    output logic [REC_W-1:0]     fifo_data_o,
    output logic                 ovf_o,
    output logic [NCH*CNT_W-1:0] evt_cnt_o,
    output logic [NCH*CNT_W-1:0] glt_cnt_o,
    output logic                 cfg_bad_o
);
    localparam int SW = NCH * (1 + FLT_W);

    logic [TS_W-1:0]      ts;
    logic [SW-1:0]        sync_q;
    logic [NCH-1:0]       s_din;
    logic [NCH*FLT_W-1:0] s_flt;
    logic [NCH-1:0]       acc, pol;
    logic [TS_W-1:0]      width [NCH];
    logic [CH_W-1:0]      sel;
    logic                 push, collide, drop;
    logic [REC_W-1:0]     rec;

    // Free-running local timebase.
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + TS_W'(1);
    end

    // Inputs and fault bits share one synchronizer so they stay aligned.
    di_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({fault_i, din_i}),
        .q_o   (sync_q)
    );
    assign s_din = sync_q[NCH-1:0];
    assign s_flt = sync_q[SW-1:NCH];

    // One debounce and classification channel per input.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        di_chan #(.TS_W(TS_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .s_i          (s_din[c]),
            .ts_i         (ts),
            .cfg_win_i    (cfg_win_i),
            .cfg_glitch_i (cfg_glitch_i),
            .cnt_clr_i    (cnt_clr_i),
            .lvl_o        (level_o[c]),
            .acc_o        (acc[c]),
            .pol_o        (pol[c]),
            .width_o      (width[c]),
            .evt_cnt_o    (evt_cnt_o[c*CNT_W +: CNT_W]),
            .glt_cnt_o    (glt_cnt_o[c*CNT_W +: CNT_W])
        );
    end

    // Lowest-numbered accepting channel wins the single write slot.
    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (acc[i]) sel = CH_W'(i);
        end
        push    = |acc;
        collide = $countones(acc) > 1;
        rec     = {sel, pol[sel], s_flt[sel*FLT_W +: FLT_W], ts, width[sel]};
    end

    di_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .din_i   (rec),
        .pop_i   (fifo_pop_i),
        .dout_o  (fifo_data_o),
        .valid_o (fifo_valid_o),
        .drop_o  (drop)
    );

    // Sticky overflow: a drop or collision sets it and wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf_o <= 1'b0;
        else if (drop || collide)   ovf_o <= 1'b1;
        else if (ovf_clr_i)         ovf_o <= 1'b0;
    end

    // Configuration check: the window must be shorter than the glitch limit.
    assign cfg_bad_o = TS_W'(cfg_win_i) >= cfg_glitch_i;

    // R8: any lost record raises the flag on the next cycle.
    a_r8_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (drop || collide) |=> ovf_o);

    // R8: the flag only falls through its clear.
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

// File: tb/tb_di_event_recorder.sv
// Directed bench for the digital input edge recorder.
module tb_di_event_recorder;
    localparam int NCH = 2, TS_W = 16, WIN_W = 8, CNT_W = 4, DEPTH = 8;
    localparam int REC_W = 1 + 1 + 3 + 2 * TS_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] din = '0;
    logic [NCH*3-1:0] fault = '0;
    logic [WIN_W-1:0] cfg_win = 8'd4;
    logic [TS_W-1:0] cfg_glitch = 16'd20;
    logic cnt_clr = 1'b0, ovf_clr = 1'b0, pop = 1'b0;
    logic [NCH-1:0] level;
    logic valid, ovf, cfg_bad;
    logic [REC_W-1:0] data;
    logic [NCH*CNT_W-1:0] evt, glt;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    di_event_recorder #(.NCH(NCH), .TS_W(TS_W), .WIN_W(WIN_W), .CNT_W(CNT_W),
                        .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .din_i(din), .fault_i(fault),
        .cfg_win_i(cfg_win), .cfg_glitch_i(cfg_glitch), .cnt_clr_i(cnt_clr),
        .ovf_clr_i(ovf_clr), .fifo_pop_i(pop), .level_o(level),
        .fifo_valid_o(valid), .fifo_data_o(data), .ovf_o(ovf),
        .evt_cnt_o(evt), .glt_cnt_o(glt), .cfg_bad_o(cfg_bad));

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Record field helpers (layout from R7).
    function automatic int f_w(input logic [REC_W-1:0] r);  return int'(r[15:0]);  endfunction
    function automatic int f_ts(input logic [REC_W-1:0] r); return int'(r[31:16]); endfunction
    function automatic int f_fl(input logic [REC_W-1:0] r); return int'(r[34:32]); endfunction
    function automatic int f_p(input logic [REC_W-1:0] r);  return int'(r[35]);    endfunction
    function automatic int f_ch(input logic [REC_W-1:0] r); return int'(r[36]);    endfunction

    task automatic settle();
        repeat (int'(cfg_win) + 6) @(negedge clk);
    endtask

    task automatic pulse(input int ch, input int len);
        din[ch] = 1'b1;
        repeat (len) @(negedge clk);
        din[ch] = 1'b0;
        settle();
    endtask

    task automatic pop_rec(output logic [REC_W-1:0] r);
        r = data;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic drain();
        logic [REC_W-1:0] r;
        while (valid) pop_rec(r);
    endtask

    task automatic clear_all();
        cnt_clr = 1'b1; ovf_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0; ovf_clr = 1'b0;
        drain();
    endtask

    task automatic t_reset();
        chk("R11 level", level, 0);
        chk("R11 valid", valid, 0);
        chk("R11 ovf", ovf, 0);
        chk("R11 evt", evt, 0);
        chk("R11 glt", glt, 0);
        chk("R10 cfg ok", cfg_bad, 0);
    endtask

    task automatic t_chatter();
        for (int k = 0; k < 3; k++) begin
            din[0] = 1'b1; repeat (4) @(negedge clk);
            din[0] = 1'b0; repeat (2) @(negedge clk);
        end
        settle();
        chk("R1 chatter level", level[0], 0);
        chk("R1 chatter no record", valid, 0);
        chk("R1 chatter no glitch", glt, 0);
    endtask

    task automatic t_latency();
        int n;
        logic [REC_W-1:0] a, b;
        n = 0;
        din[0] = 1'b1;
        while (1) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (level[0] || n > 40) break;
        end
        chk("R2 latency edges", n, int'(cfg_win) + 3);
        din[0] = 1'b0;
        settle();
        pop_rec(a); pop_rec(b);
        chk("R4 rise width zero", f_w(a), 0);
        chk("R7 rise polarity", f_p(a), 1);
        chk("R7 fall polarity", f_p(b), 0);
        chk("R3 ts delta", (f_ts(b) - f_ts(a)) & 16'hFFFF, n);
        chk("R5 short pulse is glitch", glt[3:0], 1);
        chk("R5 short pulse no event", evt[3:0], 0);
    endtask

    task automatic t_classify();
        logic [REC_W-1:0] a, b;
        clear_all();
        pulse(1, 10);
        pop_rec(a); pop_rec(b);
        chk("R7 channel field", f_ch(a), 1);
        chk("R4 width 10", f_w(b), 10);
        chk("R5 glitch ch1", glt[7:4], 1);
        pulse(1, 19);
        chk("R5 width 19 glitch", glt[7:4], 2);
        pulse(1, 20);
        chk("R5 width 20 event", evt[7:4], 1);
        pulse(1, 30);
        chk("R5 width 30 event", evt[7:4], 2);
        chk("R5 ch0 untouched", evt[3:0], 0);
        drain();
    endtask

    task automatic t_fault();
        logic [REC_W-1:0] a;
        fault[2:0] = 3'b101;
        repeat (3) @(negedge clk);
        pulse(0, 25);
        pop_rec(a);
        chk("R9 fault captured", f_fl(a), 5);
        fault = '0;
        drain();
    endtask

    task automatic t_cfg();
        cfg_win = 8'd20; #1;
        chk("R10 window equal limit", cfg_bad, 1);
        cfg_win = 8'd19; #1;
        chk("R10 window below limit", cfg_bad, 0);
        cfg_win = 8'd4;
    endtask

    task automatic t_fifo();
        logic [REC_W-1:0] r;
        int got;
        cfg_win = '0; cfg_glitch = 16'd1;
        clear_all();
        for (int k = 0; k < 5; k++) pulse(0, 3);
        chk("R8 overflow set", ovf, 1);
        got = 0;
        while (valid && got < 20) begin
            pop_rec(r);
            chk("R7 order polarity", f_p(r), (got % 2 == 0) ? 1 : 0);
            got++;
        end
        chk("R8 depth kept", got, DEPTH);
        pop = 1'b1; @(negedge clk); pop = 1'b0;
        chk("R7 empty pop", valid, 0);
        chk("R8 ovf sticky", ovf, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        chk("R8 ovf cleared", ovf, 0);
    endtask

    task automatic t_collide();
        logic [REC_W-1:0] a, b;
        din = 2'b11;
        repeat (5) @(negedge clk);
        din = 2'b00;
        settle();
        pop_rec(a); pop_rec(b);
        chk("R8 collide ch0 rise", f_ch(a), 0);
        chk("R8 collide ch0 fall", f_ch(b), 0);
        chk("R8 collide one pair", valid, 0);
        chk("R8 collide ovf", ovf, 1);
    endtask

    task automatic t_sat();
        clear_all();
        for (int k = 0; k < 17; k++) pulse(1, 3);
        chk("R6 event saturates", evt[7:4], 15);
        cnt_clr = 1'b1; @(negedge clk); cnt_clr = 1'b0;
        chk("R6 clear events", evt, 0);
        chk("R6 clear glitches", glt, 0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chatter();
        t_latency();
        t_classify();
        t_fault();
        t_cfg();
        t_fifo();
        t_collide();
        t_sat();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule